// File: doc/BRIEF.md
# Timer Bank with Channel-0 Watchdog

This block holds the register file for a bank of general-purpose timer channels, plus the one counter function that is built here: a watchdog on channel 0. Each channel has four 32-bit registers on a byte-addressed write/read port: a mode word, a counter input word, a waveform configuration word and a status word. Channels sit one after another at a stride of 0x10. Software writes and reads these words. Capture, compare, pulse-width waveforms and pin logic live elsewhere and consume the stored words.

When software puts channel 0 into watchdog mode and sets its enable bit, a counter starts from zero and advances on every clock. The terminal count comes from channel 0's counter input word. If the count reaches that value, the block emits a one-cycle system reset request, halts the counter by clearing the enable bit, and sets a sticky expiry flag in the status word.

To keep the watchdog from firing, software writes the key byte 0xA5 into the low byte of channel 0's mode word, which returns the counter to zero. The same mode setting on channels 1 to 3 only stores the bits and never counts.

Top module: `timer_bank_wdog`

## Requirements
- R1: After reset, every register of every channel reads 0, the reset request is low and the watchdog is idle.
- R2: The byte address is split as channel = addr[ADDR_W-1:4] and word = addr[3:2], where word 0 is mode, 1 is counter input, 2 is waveform configuration and 3 is status. Mode, counter input and configuration words read back what was last written, except that mode bits [7:0] always read 0.
- R3: The status word is read-only. Writes to it change nothing, and on channels 1 to 3 it always reads 0.
- R4: The watchdog runs only while channel 0's mode word has mode field bits [10:8] = 3'b100 and enable bit 12 = 1. Either condition alone does not count.
- R5: With terminal count T in channel 0's counter input word, the reset request is high in the cycle that follows the (T+1)-th rising edge after the edge that stored the enabling mode write.
- R6: A terminal count of 0 makes the request appear one edge after the enabling write.
- R7: The reset request is a one-cycle pulse. At expiry, hardware clears channel 0's enable bit, so the mode word then reads with bit 12 = 0 and the counter stays idle. Writing the enable bit again restarts the count from 0.
- R8: A write to channel 0's mode word with bits [7:0] = 0xA5 returns the counter to 0 at that edge. This happens even on the edge where expiry would otherwise occur, and the next expiry then comes T+1 edges later.
- R9: A mode word write whose low byte is not 0xA5 leaves the count running, so the expiry edge stays where it was.
- R10: Watchdog mode and enable set on channels 1 to 3 produce no reset request.
- R11: Status bit 0 of channel 0 is set by expiry, stays set through any write, and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdog_rst_o | output | 1 | One-cycle system reset request |

## Verification
The bench uses the defaults: four channels and a 32-bit counter. Four channels put the highest address (0x3C) into the decode tests and leave three non-watchdog channels to try watchdog mode on. Because the counter input word can hold any value, the bench uses small terminal counts (0, 10, 20, 30). That keeps each expiry within tens of cycles, so the exact expiry edge, the same-edge service collision and the restart after expiry can all be checked cycle by cycle.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int REG_W = 32;

  // word slot inside a channel, selected by address bits [3:2]
  typedef enum logic [1:0] {
    SLOT_MODE = 2'd0,
    SLOT_CINP = 2'd1,
    SLOT_PWMC = 2'd2,
    SLOT_STAT = 2'd3
  } slot_e;

  localparam int         MODE_LSB  = 8;
  localparam int         ENA_BIT   = 12;
  localparam logic [2:0] MODE_WDOG = 3'b100;
  localparam logic [7:0] SVC_KEY   = 8'hA5;

  function automatic slot_e slot_of(input logic [3:0] off);
    return slot_e'(off[3:2]);
  endfunction

  function automatic logic mode_is_wdog(input logic [REG_W-1:0] m);
    return m[ENA_BIT] && (m[MODE_LSB +: 3] == MODE_WDOG);
  endfunction

  function automatic logic key_match(input logic [REG_W-1:0] d);
    return d[7:0] == SVC_KEY;
  endfunction

  // key byte is a strobe field: never stored
  function automatic logic [REG_W-1:0] mode_store(input logic [REG_W-1:0] d);
    return {d[REG_W-1:8], 8'h00};
  endfunction
endpackage

// File: rtl/tmr_chan_regs.sv
`timescale 1ns/1ps
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  slot_e            slot,
  input  logic [REG_W-1:0] wdata,
  input  logic             clr_ena,
  input  logic             expired,
  output logic             wd_mode,
  output logic [CNT_W-1:0] term_cnt,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] mode_q, cinp_q, pwmc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cinp_q <= '0;
      pwmc_q <= '0;
    end else begin
      if (wr && slot == SLOT_MODE) mode_q <= mode_store(wdata);
      // expiry wins over a same-edge mode write
      if (clr_ena) mode_q[ENA_BIT] <= 1'b0;
      if (wr && slot == SLOT_CINP) cinp_q <= wdata;
      if (wr && slot == SLOT_PWMC) pwmc_q <= wdata;
    end
  end

  assign wd_mode  = mode_is_wdog(mode_q);
  assign term_cnt = cinp_q[CNT_W-1:0];

  always_comb begin
    unique case (slot)
      SLOT_MODE: rdata = mode_q;
      SLOT_CINP: rdata = cinp_q;
      SLOT_PWMC: rdata = pwmc_q;
      default:   rdata = {{(REG_W-1){1'b0}}, expired};
    endcase
  end

  // R2: counter input word only moves on its own write
  a_r2_cinp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && slot == SLOT_CINP) |=> $stable(cinp_q));
  // R7: hardware clear always lands
  a_r7_ena_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ena |=> !mode_q[ENA_BIT]);
endmodule

// File: rtl/tmr_wdog.sv
`timescale 1ns/1ps
module tmr_wdog #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             svc,
  input  logic [CNT_W-1:0] tc,
  output logic             hit,
  output logic             fire,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  assign hit = active && !svc && (cnt_q == tc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fire    <= 1'b0;
      expired <= 1'b0;
    end else begin
      fire <= hit;
      if (hit) expired <= 1'b1;
      if (!active || svc) cnt_q <= '0;
      else if (!hit)      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: pulse lasts one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R5: request only follows a cycle where the count equalled the limit
  a_r5_fire_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(cnt_q == tc));
  // R8: service zeroes the count and blocks the request
  a_r8_svc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> (cnt_q == '0) && !fire);
  // R11: sticky flag
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired);
endmodule

// File: rtl/timer_bank_wdog.sv
`timescale 1ns/1ps
module timer_bank_wdog
  import tmr_pkg::*;
#(
  parameter  int N_CH   = 4,
  parameter  int CNT_W  = 32,
  localparam int CH_W   = $clog2(N_CH),
  localparam int ADDR_W = CH_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              wdog_rst_o
);
  localparam int WD_CH = 0;

  slot_e            slot;
  logic [CH_W-1:0]  ch_sel;
  logic             wr_vec  [N_CH];
  logic             act_arr [N_CH];
  logic [CNT_W-1:0] tc_arr  [N_CH];
  logic [REG_W-1:0] rd_arr  [N_CH];

  logic wd_active, wd_svc, wd_hit, wd_fire, wd_expired;

  assign slot   = slot_of(bus_addr[3:0]);
  assign ch_sel = bus_addr[ADDR_W-1:4];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign wr_vec[c] = bus_wr && (ch_sel == CH_W'(c));
    if (c == WD_CH) begin : g_wd
      tmr_chan_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(wr_vec[c]), .slot(slot),
        .wdata(bus_wdata), .clr_ena(wd_hit), .expired(wd_expired),
        .wd_mode(act_arr[c]), .term_cnt(tc_arr[c]), .rdata(rd_arr[c]));
    end else begin : g_plain
      tmr_chan_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(wr_vec[c]), .slot(slot),
        .wdata(bus_wdata), .clr_ena(1'b0), .expired(1'b0),
        .wd_mode(act_arr[c]), .term_cnt(tc_arr[c]), .rdata(rd_arr[c]));
    end
  end

  assign wd_active = act_arr[WD_CH];
  assign wd_svc    = wr_vec[WD_CH] && (slot == SLOT_MODE) && key_match(bus_wdata);

  tmr_wdog #(.CNT_W(CNT_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .active(wd_active), .svc(wd_svc),
    .tc(tc_arr[WD_CH]), .hit(wd_hit), .fire(wd_fire), .expired(wd_expired));

  assign bus_rdata  = rd_arr[ch_sel];
  assign wdog_rst_o = wd_fire;

  // R7: once fired, the watchdog is no longer enabled
  a_r7_halted: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |-> !wd_active);
  // R4/R10: a request needs channel 0 to have been armed
  a_r10_ch0_only: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |-> $past(wd_active));
  // R11: flag rises only together with a request
  a_r11_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_expired) |-> wd_fire);
endmodule

// File: tb/test_timer_bank_wdog.sv
`timescale 1ns/1ps
module test_timer_bank_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdog_rst_o;

  int n_chk = 0, n_bad = 0, cyc = 0, n_pulse = 0, last_pulse = -1;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && wdog_rst_o) begin
    n_pulse++;
    last_pulse = cyc;
  end

  timer_bank_wdog i_timer_bank_wdog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_rst_o(wdog_rst_o));

  // {addr, write data, expected read-back}
  localparam logic [71:0] VECS [0:10] = '{
    {8'h10, 32'hFFFF_FFFF, 32'hFFFF_FF00},  // R2 key byte reads 0
    {8'h14, 32'h1234_5678, 32'h1234_5678},  // R2
    {8'h28, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R2
    {8'h34, 32'h0000_00A5, 32'h0000_00A5},  // R2
    {8'h30, 32'h0000_14A5, 32'h0000_1400},  // R2, arms ch3 for R10
    {8'h08, 32'hCAFE_0001, 32'hCAFE_0001},  // R2
    {8'h04, 32'h0000_0100, 32'h0000_0100},  // R2
    {8'h2C, 32'hFFFF_FFFF, 32'h0000_0000},  // R3
    {8'h0C, 32'hFFFF_FFFF, 32'h0000_0000},  // R3
    {8'h00, 32'h0000_03FF, 32'h0000_0300},  // R2, not watchdog mode
    {8'h3C, 32'h0000_0001, 32'h0000_0000}   // R3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the store edge index
  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int w);
    bus_addr = a[5:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    w = cyc;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a[5:0];
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_fire(input string tag, input int exp_cyc, input int p0);
    wait_until(exp_cyc + 3);
    chk({tag, " pulse count"}, 32'(n_pulse), 32'(p0 + 1));
    chk({tag, " pulse cycle"}, 32'(last_pulse), 32'(exp_cyc));
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int w, w2, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 64; a += 4) begin
      rd(8'(a), r);
      chk($sformatf("R1 reset read %02h", a), r, 32'h0);
    end
    chk("R1 reset request low", 32'(wdog_rst_o), 32'h0);

    // R2/R3 vector table
    for (int i = 0; i < 11; i++) begin
      wr(VECS[i][71:64], VECS[i][63:32], w);
      rd(VECS[i][71:64], r);
      chk($sformatf("R2/R3 vector %0d", i), r, VECS[i][31:0]);
    end

    // R10 ch3 in watchdog mode stays silent
    p0 = n_pulse;
    repeat (300) @(negedge clk);
    chk("R10 no request from ch3", 32'(n_pulse), 32'(p0));
    rd(8'h3C, r); chk("R10 ch3 status", r, 32'h0);
    wr(8'h30, 32'h0, w);

    // R4 partial settings do not count
    wr(8'h04, 32'd5, w);
    p0 = n_pulse;
    wr(8'h00, 32'h0000_1300, w);
    repeat (40) @(negedge clk);
    chk("R4 enable without mode", 32'(n_pulse), 32'(p0));
    wr(8'h00, 32'h0000_0400, w);
    repeat (40) @(negedge clk);
    chk("R4 mode without enable", 32'(n_pulse), 32'(p0));
    wr(8'h00, 32'h0, w);

    // R5 expiry timing
    wr(8'h04, 32'd20, w);
    p0 = n_pulse;
    wr(8'h00, 32'h0000_1400, w);
    expect_fire("R5", w + 21, p0);
    rd(8'h0C, r); chk("R11 status set", r, 32'h1);
    rd(8'h00, r); chk("R7 enable cleared", r, 32'h0000_0400);
    p0 = n_pulse;
    repeat (50) @(negedge clk);
    chk("R7 halted", 32'(n_pulse), 32'(p0));
    wr(8'h00, 32'h0000_1400, w);
    expect_fire("R7 restart", w + 21, p0);

    // R6 zero terminal count
    wr(8'h04, 32'd0, w);
    p0 = n_pulse;
    wr(8'h00, 32'h0000_1400, w);
    expect_fire("R6", w + 1, p0);

    // R9 wrong key
    wr(8'h04, 32'd30, w);
    p0 = n_pulse;
    wr(8'h00, 32'h0000_1400, w);
    wait_until(w + 10);
    wr(8'h00, 32'h0000_145A, w2);
    expect_fire("R9", w + 31, p0);

    // R8 service mid-count
    p0 = n_pulse;
    wr(8'h00, 32'h0000_1400, w);
    wait_until(w + 20);
    wr(8'h00, 32'h0000_14A5, w2);
    expect_fire("R8 service", w2 + 31, p0);

    // R8 service on the expiry edge
    wr(8'h04, 32'd10, w);
    p0 = n_pulse;
    wr(8'h00, 32'h0000_1400, w);
    wait_until(w + 10);
    wr(8'h00, 32'h0000_14A5, w2);
    chk("R8 collision edge", 32'(w2), 32'(w + 11));
    expect_fire("R8 collision", w2 + 11, p0);

    // R11 sticky through writes, cleared by reset
    wr(8'h0C, 32'h0, w);
    rd(8'h0C, r); chk("R11 status survives write", r, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h0C, r); chk("R11 status cleared by reset", r, 32'h0);
    rd(8'h00, r); chk("R1 mode after reset", r, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule